// File: doc/BRIEF.md
# Packed-Element Register Slice Sequencer

This block walks a packed-SIMD vector operation element by element. Software supplies four things: an element-width code, a vector length counted in whole registers, the number of the first register and a predicate mask. A single-cycle start pulse launches the walk. The block works out how many elements fit in one XLEN-bit register. It scales the vector length by that packing factor, then steps one element index per clock. For each element whose predicate bit is set, it emits the physical register that holds the element and the bit range of the element inside that register.

The width code selects the element size. A code of zero means the full register width. Codes 1 through 5 select 8, 16, 32, 64 and 128 bits. The packing factor is always a power of two, so the split of an element index into a register offset and a slot is a shift and a mask, not a divider. An unusable width stops the walk before any element is issued and raises an error pulse alongside the completion pulse. Unusable widths are the two reserved codes and any width larger than XLEN.

Top module: `simd_slice_seq`

## Requirements
- R1: Width code 0 selects an element of XLEN bits. Codes 1, 2, 3, 4 and 5 select 8, 16, 32, 64 and 128 bits. On every strobe, acc_hi_o − acc_lo_o + 1 equals the selected width.
- R2: The packing factor is XLEN divided by the element width. The walk covers exactly vl_i × packing-factor element indices, and the number of strobes equals the count of set mask bits among those indices.
- R3: For element index i, acc_reg_o equals base_reg_i + floor(i / packing factor), taken modulo 2^REG_W, so the register number wraps around.
- R4: For element index i, acc_lo_o equals (i mod packing factor) × width and acc_hi_o equals acc_lo_o + width − 1.
- R5: Start is sampled on a rising edge. Element index k is presented in the k-th cycle after that edge (k = 0 is the cycle right after it), in ascending order with no gaps. done_o stays low during the walk.
- R6: Bit i of pred_mask_i belongs to element index i. A clear bit gives acc_valid_o low in that element's cycle, but the index still uses its cycle. While acc_valid_o is low, acc_reg_o, acc_lo_o and acc_hi_o read zero.
- R7: done_o is high for exactly one cycle: the cycle after the last element index.
- R8: An effective length of zero (vl_i = 0 with a legal code) raises done_o in the cycle after start, with no strobe and illegal_o low.
- R9: Codes 6 and 7, and any width wider than XLEN (code 5 when XLEN = 64), raise illegal_o together with done_o for one cycle after start. No strobe is issued.
- R10: Start, and any change to the configuration inputs, is ignored from the cycle after an accepted start until the cycle after done_o. The running walk keeps the configuration it captured at start.
- R11: An active-low reset forces acc_valid_o, done_o, illegal_o and all slice outputs to zero at once, without waiting for a clock edge. Reset is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start request, accepted when idle |
| ew_code_i | input | 3 | Element-width code |
| vl_i | input | VL_W (3) | Vector length in whole registers |
| base_reg_i | input | REG_W (5) | First register number |
| pred_mask_i | input | MASK_W (64) | Predicate, one bit per element index |
| acc_valid_o | output | 1 | Element access strobe |
| acc_reg_o | output | REG_W (5) | Physical register holding the element |
| acc_lo_o | output | log2(XLEN) (6) | Lowest bit of the element slice |
| acc_hi_o | output | log2(XLEN) (6) | Highest bit of the element slice |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Unusable width, pulses with done_o |

## Verification
The hardest situation to reach from the ports is a start request, with changed configuration, arriving while a walk is already under way. Normal stimulus never raises start during a walk. The stimulus therefore raises start in the middle of a long walk and, in the same cycle, drives a reserved width code and an inverted base register. It then checks that every later strobe still uses the captured setup. A second hard case is a register number that wraps past the top of the register space. This needs a base register near the top together with a long enough effective length, and the vector table includes such entries. Reset is also asserted partway through a walk, and the outputs are checked before the next clock edge.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  // width of shift amounts that carry log2 quantities between units
  localparam int SHAMT_W = 8;
  typedef logic [SHAMT_W-1:0] shamt_t;

  localparam int CODE_W = 3;
  // highest code that names a width at all (128 bits)
  localparam logic [CODE_W-1:0] CODE_MAX_NAMED = 3'd5;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;

endpackage

// File: rtl/ssq_width_decode.sv
module ssq_width_decode
  import ssq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              illegal_o,
  output shamt_t            pack_sh_o,   // log2 of elements per register
  output shamt_t            elem_lb_o    // log2 of element width in bits
);

  localparam int LOG_XB = $clog2(XLEN / 8);

  int lb_bytes;

  always_comb begin
    if (code_i == '0) lb_bytes = LOG_XB;
    else              lb_bytes = int'(code_i) - 1;
    illegal_o = (code_i > CODE_MAX_NAMED) || (lb_bytes > LOG_XB);
    pack_sh_o = illegal_o ? '0 : shamt_t'(LOG_XB - lb_bytes);
    elem_lb_o = illegal_o ? shamt_t'(LOG_XB + 3) : shamt_t'(lb_bytes + 3);
  end

endmodule

// File: rtl/ssq_slice_map.sv
module ssq_slice_map
  import ssq_pkg::*;
#(
  parameter  int XLEN  = 64,
  parameter  int REG_W = 5,
  parameter  int IDX_W = 6,
  localparam int BIT_W = $clog2(XLEN)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] base_i,
  input  shamt_t           pack_sh_i,
  input  shamt_t           elem_lb_i,
  output logic [REG_W-1:0] reg_o,
  output logic [BIT_W-1:0] lo_o,
  output logic [BIT_W-1:0] hi_o
);

  logic [IDX_W-1:0] reg_off;
  logic [IDX_W-1:0] slot_mask;
  logic [IDX_W-1:0] slot;
  logic [BIT_W-1:0] span_m1;

  // power-of-two packing: quotient by shift, remainder by mask
  always_comb begin
    reg_off   = idx_i >> pack_sh_i;
    slot_mask = ~({IDX_W{1'b1}} << pack_sh_i);
    slot      = idx_i & slot_mask;
    span_m1   = ~({BIT_W{1'b1}} << elem_lb_i);
    lo_o      = BIT_W'(slot) << elem_lb_i;
    hi_o      = lo_o | span_m1;   // lo is aligned to the span
  end

  assign reg_o = base_i + REG_W'(reg_off);

endmodule

// File: rtl/ssq_seq_ctrl.sv
module ssq_seq_ctrl
  import ssq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             illegal_i,
  input  logic [IDX_W-1:0] len_i,
  output logic             accept_o,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             err_o
);

  sq_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             err_q, err_d;
  logic             st_en;

  assign accept_o = start_i && (state_q == SQ_IDLE);
  assign st_en    = accept_o || (state_q != SQ_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    err_d   = err_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (accept_o) begin
          idx_d = '0;
          if (illegal_i) begin
            state_d = SQ_DONE;
            err_d   = 1'b1;
          end else if (len_i == '0) begin
            state_d = SQ_DONE;
            err_d   = 1'b0;
          end else begin
            state_d = SQ_RUN;
            err_d   = 1'b0;
            last_d  = len_i - IDX_W'(1);
          end
        end
      end
      SQ_RUN: begin
        if (idx_q == last_q) state_d = SQ_DONE;
        else                 idx_d   = idx_q + IDX_W'(1);
      end
      SQ_DONE: begin
        state_d = SQ_IDLE;
        err_d   = 1'b0;
        idx_d   = '0;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      err_q   <= 1'b0;
    end else if (st_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      err_q   <= err_d;
    end
  end

  assign run_o  = (state_q == SQ_RUN);
  assign idx_o  = idx_q;
  assign done_o = (state_q == SQ_DONE);
  assign err_o  = err_q;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: consecutive walking cycles advance the index by exactly one
  p_index_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && $past(run_o)) |-> (idx_o == $past(idx_o) + IDX_W'(1)));

  // R9: the error flag only appears together with completion
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R8: an accepted zero-length legal request finishes at once
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !illegal_i && len_i == '0) |=> (done_o && !run_o && !err_o));

  // R9: an accepted unusable request never enters the walk
  p_illegal_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && illegal_i) |=> (done_o && err_o && !run_o));

endmodule

// File: rtl/simd_slice_seq.sv
module simd_slice_seq
  import ssq_pkg::*;
#(
  parameter  int XLEN   = 64,
  parameter  int REG_W  = 5,
  parameter  int VL_W   = 3,
  localparam int IDX_W  = VL_W + $clog2(XLEN / 8),
  localparam int MASK_W = 1 << IDX_W,
  localparam int BIT_W  = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] ew_code_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [REG_W-1:0]  base_reg_i,
  input  logic [MASK_W-1:0] pred_mask_i,
  output logic              acc_valid_o,
  output logic [REG_W-1:0]  acc_reg_o,
  output logic [BIT_W-1:0]  acc_lo_o,
  output logic [BIT_W-1:0]  acc_hi_o,
  output logic              done_o,
  output logic              illegal_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // decode of the request as presented at the ports
  logic             dec_illegal;
  shamt_t           dec_sh, dec_lb;
  logic [IDX_W-1:0] dec_len;

  ssq_width_decode #(.XLEN(XLEN)) u_dec (
    .code_i    (ew_code_i),
    .illegal_o (dec_illegal),
    .pack_sh_o (dec_sh),
    .elem_lb_o (dec_lb)
  );

  assign dec_len = IDX_W'(vl_i) << dec_sh;

  // sequencing
  logic             accept, run;
  logic [IDX_W-1:0] idx;

  ssq_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_i   (start_i),
    .illegal_i (dec_illegal),
    .len_i     (dec_len),
    .accept_o  (accept),
    .run_o     (run),
    .idx_o     (idx),
    .done_o    (done_o),
    .err_o     (illegal_o)
  );

  // configuration captured once per accepted request
  logic [REG_W-1:0]  base_q;
  logic [MASK_W-1:0] mask_q;
  shamt_t            sh_q, lb_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      base_q <= '0;
      mask_q <= '0;
      sh_q   <= '0;
      lb_q   <= '0;
    end else if (accept) begin
      base_q <= base_reg_i;
      mask_q <= pred_mask_i;
      sh_q   <= dec_sh;
      lb_q   <= dec_lb;
    end
  end

  // element index to register and slice
  logic [REG_W-1:0] map_reg;
  logic [BIT_W-1:0] map_lo, map_hi;

  ssq_slice_map #(.XLEN(XLEN), .REG_W(REG_W), .IDX_W(IDX_W)) u_map (
    .idx_i     (idx),
    .base_i    (base_q),
    .pack_sh_i (sh_q),
    .elem_lb_i (lb_q),
    .reg_o     (map_reg),
    .lo_o      (map_lo),
    .hi_o      (map_hi)
  );

  assign acc_valid_o = run && mask_q[idx];
  assign acc_reg_o   = acc_valid_o ? map_reg : '0;
  assign acc_lo_o    = acc_valid_o ? map_lo  : '0;
  assign acc_hi_o    = acc_valid_o ? map_hi  : '0;

  logic [BIT_W:0] slice_span;
  assign slice_span = ({1'b0, acc_hi_o} - {1'b0, acc_lo_o}) + (BIT_W+1)'(1);

  // R1: each strobed slice spans a power-of-two number of bits
  p_slice_pow2_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    acc_valid_o |-> ($countones(slice_span) == 1));

  // R10: captured setup does not move while the walk runs
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run && $past(run)) |-> ($stable(base_q) && $stable(mask_q) && $stable(sh_q)));

  // R6: no strobe outside the walk
  p_quiet_done_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_o |-> !acc_valid_o);

endmodule

// File: tb/tb_simd_slice_seq.sv
module tb_simd_slice_seq;

  localparam int XLEN = 64;
  localparam int XB   = XLEN / 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  ew_code_i;
  logic [2:0]  vl_i;
  logic [4:0]  base_reg_i;
  logic [63:0] pred_mask_i;
  logic        acc_valid_o;
  logic [4:0]  acc_reg_o;
  logic [5:0]  acc_lo_o, acc_hi_o;
  logic        done_o, illegal_o;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  simd_slice_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ew_code_i(ew_code_i),
    .vl_i(vl_i), .base_reg_i(base_reg_i), .pred_mask_i(pred_mask_i),
    .acc_valid_o(acc_valid_o), .acc_reg_o(acc_reg_o), .acc_lo_o(acc_lo_o),
    .acc_hi_o(acc_hi_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  // {code, vl, base, mask}
  localparam logic [74:0] VECS [7] = '{
    {3'd1, 3'd2, 5'd3,  64'hFFFF_FFFF_FFFF_FFFF},
    {3'd2, 3'd3, 5'd30, 64'hAAAA_AAAA_AAAA_AAAA},
    {3'd3, 3'd1, 5'd0,  64'h0000_0000_0000_0001},
    {3'd4, 3'd4, 5'd7,  64'h0000_0000_0000_00F5},
    {3'd0, 3'd7, 5'd31, 64'h0000_0000_0000_005B},
    {3'd1, 3'd7, 5'd10, 64'hFFFF_0000_FFFF_0F0F},
    {3'd2, 3'd1, 5'd1,  64'h0000_0000_0000_0000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_quiet(input string req);
    check(acc_valid_o == 1'b0, req, "valid", acc_valid_o, 0);
    check(acc_reg_o == '0 && acc_lo_o == '0 && acc_hi_o == '0, req, "slice zero",
          {acc_reg_o, acc_lo_o, acc_hi_o}, 0);
  endtask

  // caller sits just after a falling edge; returns likewise
  task automatic run_seq(input logic [2:0] code, input logic [2:0] vl,
                         input logic [4:0] base, input logic [63:0] mask,
                         input bit poke);
    int bytes, mult, w, len, strobes, exp_strobes;
    bit ill;
    ill   = (code > 3'd5);
    bytes = (code == 3'd0) ? XB : (1 << (int'(code) - 1));
    if (!ill && bytes > XB) ill = 1'b1;
    mult  = ill ? 1 : XB / bytes;
    w     = bytes * 8;
    len   = ill ? 0 : int'(vl) * mult;
    strobes = 0;
    exp_strobes = 0;

    ew_code_i = code; vl_i = vl; base_reg_i = base; pred_mask_i = mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;

    if (len == 0) begin
      // R8 / R9: finish at once with no strobe
      check(done_o == 1'b1, ill ? "R9" : "R8", "done", done_o, 1);
      check(illegal_o == ill, ill ? "R9" : "R8", "illegal", illegal_o, ill);
      check_quiet(ill ? "R9" : "R8");
    end else begin
      for (int k = 0; k < len; k++) begin
        bit ev;
        int er, elo;
        ev  = mask[k];
        er  = (int'(base) + k / mult) % 32;
        elo = (k % mult) * w;
        if (ev) exp_strobes++;
        if (acc_valid_o) strobes++;
        check(acc_valid_o == ev, "R6", "valid", acc_valid_o, ev);
        check(done_o == 1'b0, "R5", "done during walk", done_o, 0);
        if (ev) begin
          check(acc_reg_o == 5'(er), "R3", "register", acc_reg_o, er);
          check(acc_lo_o == 6'(elo), "R4", "low bit", acc_lo_o, elo);
          check(acc_hi_o == 6'(elo + w - 1), "R1", "high bit", acc_hi_o, elo + w - 1);
        end else begin
          check(acc_reg_o == '0 && acc_lo_o == '0 && acc_hi_o == '0, "R6",
                "slice while masked", {acc_reg_o, acc_lo_o, acc_hi_o}, 0);
        end
        // R10: interfering request mid-walk
        if (poke && k == 1) begin
          start_i = 1'b1; ew_code_i = 3'd6; base_reg_i = base ^ 5'h1F;
          pred_mask_i = ~mask;
        end else if (poke && k == 2) begin
          start_i = 1'b0; ew_code_i = code; base_reg_i = base; pred_mask_i = mask;
        end
        @(negedge clk);
      end
      check(done_o == 1'b1, "R7", "done after last", done_o, 1);
      check(illegal_o == 1'b0, "R7", "illegal on legal walk", illegal_o, 0);
      check_quiet("R7");
      check(strobes == exp_strobes, "R2", "strobe count", strobes, exp_strobes);
    end
    @(negedge clk);
    check(done_o == 1'b0, "R7", "done single cycle", done_o, 0);
    check(illegal_o == 1'b0, "R9", "illegal single cycle", illegal_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ew_code_i = '0; vl_i = '0;
    base_reg_i = '0; pred_mask_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done_o == 1'b0 && illegal_o == 1'b0, "R11", "flags in reset",
          {done_o, illegal_o}, 0);
    check_quiet("R11");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done_o == 1'b0, "R11", "idle after release", done_o, 0);

    // table walk: R1, R2, R3, R4, R5, R6, R7
    for (int v = 0; v < 7; v++)
      run_seq(VECS[v][74:72], VECS[v][71:69], VECS[v][68:64], VECS[v][63:0], 1'b0);

    // R8: zero length
    run_seq(3'd1, 3'd0, 5'd4, 64'hFF, 1'b0);
    // R9: unusable widths
    run_seq(3'd5, 3'd3, 5'd4, 64'hFF, 1'b0);
    run_seq(3'd6, 3'd2, 5'd4, 64'hFF, 1'b0);
    run_seq(3'd7, 3'd0, 5'd4, 64'hFF, 1'b0);
    // R10: start and new setup during a walk are ignored
    run_seq(3'd2, 3'd2, 5'd29, 64'h0000_0000_0000_00B7, 1'b1);
    run_seq(3'd0, 3'd5, 5'd12, 64'h0000_0000_0000_001F, 1'b1);

    // R11: reset mid-walk clears outputs before the next edge
    ew_code_i = 3'd1; vl_i = 3'd4; base_reg_i = 5'd2; pred_mask_i = '1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(acc_valid_o == 1'b1, "R11", "walk running before reset", acc_valid_o, 1);
    #2 rst_n = 1'b0;
    #1;
    check(done_o == 1'b0 && illegal_o == 1'b0, "R11", "flags at reset",
          {done_o, illegal_o}, 0);
    check_quiet("R11");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R11");
    run_seq(3'd3, 3'd2, 5'd0, 64'h0000_0000_0000_000D, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule